// File: doc/BRIEF.md
# Monotonic Security Level Gate

The gate keeps a protection level for an on-chip program memory and rules on every memory or configuration request before it reaches the array. Each request names an operation class. For a set-level request it also carries a target level code. One clock later the gate returns a response strobe. The strobe carries an allow/deny verdict and the character code that the reply formatter sends back to the host. It also carries a restore strobe that tells the configuration store to return the boot status byte to FFh and the software boot vector to FCh.

The level is a three-state machine. The states are LV_OPEN (code FFh), LV_WPROT (code FEh) and LV_RWPROT (code FCh). The level codes only ever clear bits as protection rises. There are four transitions. OPEN_TO_WPROT and OPEN_TO_RWPROT are taken on an accepted set-level request. WPROT_TO_RWPROT is taken on an accepted set-level request to FCh. ANY_TO_OPEN is taken on a full-chip erase. Nothing else moves the level downward. The verdict is combinational on the current state and the request, and the response register captures it. The response therefore always reflects the level as it stood before the request.

Top module: `sec_level_gate`

## Requirements
- R1: After reset `level_code` is FFh and `rsp_valid` is low. At all times `level_code` holds one of FFh, FEh or FCh.
- R2: A set-level request (`req_op`=6) is allowed with code 2Eh when its target is strictly more protected than the current level. The ranking is FFh < FEh < FCh. `level_code` shows the target in the response cycle.
- R3: A set-level request to an equal, lower or unrecognised code (anything but FFh, FEh, FCh) is denied with code 50h, and `level_code` stays unchanged.
- R4: At FEh, program write (`req_op`=1), block erase (`req_op`=2) and boot-byte write (`req_op`=4) are denied with code 50h. Program read (`req_op`=0) is allowed.
- R5: At FCh, program read (`req_op`=0) is denied with code 4Ch. Program write, block erase and boot-byte write are denied with code 50h.
- R6: A full-chip erase (`req_op`=3) is allowed at every level. It raises `rsp_restore` with the response and sets `level_code` to FFh.
- R7: An identity read (`req_op`=5) is allowed at every level.
- R8: At FFh, ops 0, 1, 2, 4 and 5 are all allowed. Every allowed response carries code 2Eh.
- R9: `rsp_valid` rises exactly one cycle after each sampled request and is low when no request was sampled. The verdict uses the level held before that request.
- R10: The reserved class (`req_op`=7) is denied with code 50h at every level and changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 3 | Operation class, encoded as in R2 to R10 |
| req_level | input | 8 | Target level code for set-level requests |
| rsp_valid | output | 1 | Response strobe, one cycle after a request |
| rsp_allow | output | 1 | Request may proceed |
| rsp_code | output | 8 | Reply character: 2Eh ok, 50h write refused, 4Ch read refused |
| rsp_restore | output | 1 | Full-chip erase accepted; restore boot bytes to defaults |
| level_code | output | 8 | Current protection level code |

## Verification
The bench brings the gate to each of the three levels through its normal request path. At each level it applies every operation class. It also applies set-level requests with the three legal codes and with three unrecognised ones. A per-level sweep over classes separates the read-refusal code from the write-refusal code and shows which operations each level still permits. The set-level sweep separates a genuine raise from equal, lower and malformed targets. The setup itself places requests back to back, with a set followed at once by another request. This shows that the verdict uses the level before the change and that a full erase returns the level to FFh from any state.

// File: rtl/sec_gate_pkg.sv
package sec_gate_pkg;

    localparam int OP_W   = 3;
    localparam int CODE_W = 8;

    typedef enum logic [OP_W-1:0] {
        OP_RD_MEM  = 3'd0,
        OP_WR_MEM  = 3'd1,
        OP_ER_BLK  = 3'd2,
        OP_ER_ALL  = 3'd3,
        OP_WR_CFG  = 3'd4,
        OP_RD_ID   = 3'd5,
        OP_SET_LVL = 3'd6,
        OP_RSVD    = 3'd7
    } op_e;

    // Rank order matters: a larger value is more protected.
    typedef enum logic [1:0] {
        LV_OPEN   = 2'd0,
        LV_WPROT  = 2'd1,
        LV_RWPROT = 2'd2
    } lvl_e;

    localparam logic [CODE_W-1:0] CODE_OPEN   = 8'hFF;
    localparam logic [CODE_W-1:0] CODE_WPROT  = 8'hFE;
    localparam logic [CODE_W-1:0] CODE_RWPROT = 8'hFC;

    localparam logic [CODE_W-1:0] RC_OK       = 8'h2E;
    localparam logic [CODE_W-1:0] RC_WR_DENY  = 8'h50;
    localparam logic [CODE_W-1:0] RC_RD_DENY  = 8'h4C;

    typedef struct packed {
        logic              allow;
        logic [CODE_W-1:0] code;
        logic              restore;
    } verdict_t;

endpackage

// File: rtl/sec_gate_decode.sv
module sec_gate_decode
    import sec_gate_pkg::*;
(
    input  lvl_e                cur_lvl,
    input  logic [OP_W-1:0]     op,
    input  logic [CODE_W-1:0]   tgt_code,
    output verdict_t            vd,
    output lvl_e                nxt_lvl,
    output logic                lvl_load
);

    logic tgt_known;
    lvl_e tgt_lvl;

    always_comb begin
        tgt_known = 1'b1;
        tgt_lvl   = LV_OPEN;
        unique case (tgt_code)
            CODE_OPEN:   tgt_lvl = LV_OPEN;
            CODE_WPROT:  tgt_lvl = LV_WPROT;
            CODE_RWPROT: tgt_lvl = LV_RWPROT;
            default:     tgt_known = 1'b0;
        endcase
    end

    always_comb begin
        vd.allow   = 1'b0;
        vd.code    = RC_WR_DENY;
        vd.restore = 1'b0;
        nxt_lvl    = cur_lvl;
        lvl_load   = 1'b0;
        unique case (op_e'(op))
            OP_RD_MEM: begin
                if (cur_lvl == LV_RWPROT) vd.code  = RC_RD_DENY;
                else                      vd.allow = 1'b1;
            end
            OP_WR_MEM, OP_ER_BLK, OP_WR_CFG: begin
                vd.allow = (cur_lvl == LV_OPEN);
            end
            OP_ER_ALL: begin
                vd.allow   = 1'b1;
                vd.restore = 1'b1;
                nxt_lvl    = LV_OPEN;
                lvl_load   = 1'b1;
            end
            OP_RD_ID: begin
                vd.allow = 1'b1;
            end
            OP_SET_LVL: begin
                if (tgt_known && (tgt_lvl > cur_lvl)) begin
                    vd.allow = 1'b1;
                    nxt_lvl  = tgt_lvl;
                    lvl_load = 1'b1;
                end
            end
            default: begin
                vd.allow = 1'b0;
            end
        endcase
        if (vd.allow) vd.code = RC_OK;
    end

endmodule

// File: rtl/sec_gate_resp.sv
module sec_gate_resp
    import sec_gate_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  verdict_t          vd,
    output logic              rsp_valid,
    output logic              rsp_allow,
    output logic [CODE_W-1:0] rsp_code,
    output logic              rsp_restore
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid   <= 1'b0;
            rsp_allow   <= 1'b0;
            rsp_code    <= '0;
            rsp_restore <= 1'b0;
        end else begin
            rsp_valid   <= req_valid;
            rsp_allow   <= req_valid & vd.allow;
            rsp_code    <= req_valid ? vd.code : '0;
            rsp_restore <= req_valid & vd.restore;
        end
    end

    AST_STROBE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid); // R9
    AST_NO_SPURIOUS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid); // R9
    AST_OK_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_allow) |-> (rsp_code == RC_OK)); // R8
    AST_DENY_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_allow) |-> (rsp_code == RC_WR_DENY || rsp_code == RC_RD_DENY)); // R5

endmodule

// File: rtl/sec_level_gate.sv
module sec_level_gate
    import sec_gate_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic [2:0]  req_op,
    input  logic [7:0]  req_level,
    output logic        rsp_valid,
    output logic        rsp_allow,
    output logic [7:0]  rsp_code,
    output logic        rsp_restore,
    output logic [7:0]  level_code
);

    lvl_e     state_q;
    lvl_e     state_nxt;
    logic     lvl_load;
    verdict_t vd;

    sec_gate_decode u_decode (
        .cur_lvl  (state_q),
        .op       (req_op),
        .tgt_code (req_level),
        .vd       (vd),
        .nxt_lvl  (state_nxt),
        .lvl_load (lvl_load)
    );

    // State register: the protection level itself.
    always_ff @(posedge clk) begin
        if (!rst_n)                     state_q <= LV_OPEN;
        else if (req_valid && lvl_load) state_q <= state_nxt;
    end

    // Output process: level code presented to the rest of the chip.
    always_comb begin
        unique case (state_q)
            LV_OPEN:   level_code = CODE_OPEN;
            LV_WPROT:  level_code = CODE_WPROT;
            LV_RWPROT: level_code = CODE_RWPROT;
            default:   level_code = CODE_RWPROT;
        endcase
    end

    sec_gate_resp u_resp (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .vd          (vd),
        .rsp_valid   (rsp_valid),
        .rsp_allow   (rsp_allow),
        .rsp_code    (rsp_code),
        .rsp_restore (rsp_restore)
    );

    AST_LEVEL_ENCODED: assert property (@(posedge clk) disable iff (!rst_n)
        (level_code == CODE_OPEN || level_code == CODE_WPROT || level_code == CODE_RWPROT)); // R1
    AST_TOP_NEVER_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(level_code) == CODE_RWPROT && level_code != CODE_RWPROT) |-> (level_code == CODE_OPEN)); // R2
    AST_LOWER_ONLY_BY_ERASE: assert property (@(posedge clk) disable iff (!rst_n)
        (level_code == CODE_OPEN && $past(level_code) != CODE_OPEN)
            |-> $past(req_valid && req_op == 3'd3)); // R6
    AST_ERASE_ALWAYS_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == 3'd3) |=> (rsp_allow && rsp_restore && level_code == CODE_OPEN)); // R6
    AST_ID_ALWAYS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == 3'd5) |=> rsp_allow); // R7
    AST_RSVD_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == 3'd7) |=> (!rsp_allow && $stable(level_code))); // R10

endmodule

// File: tb/tb_sec_level_gate.sv
module tb_sec_level_gate;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic [2:0] req_op = '0;
    logic [7:0] req_level = '0;
    logic       rsp_valid, rsp_allow, rsp_restore;
    logic [7:0] rsp_code, level_code;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;
    logic [7:0] m_lvl = 8'hFF;

    always #2 clk = ~clk;

    sec_level_gate dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_level(req_level), .rsp_valid(rsp_valid), .rsp_allow(rsp_allow),
        .rsp_code(rsp_code), .rsp_restore(rsp_restore), .level_code(level_code)
    );

    function automatic int rank(input logic [7:0] c);
        case (c)
            8'hFF:   return 0;
            8'hFE:   return 1;
            8'hFC:   return 2;
            default: return -1;
        endcase
    endfunction

    function automatic string tag(input logic [7:0] lv, input int op);
        if (op == 6) return "R2/R3";
        if (op == 3) return "R6";
        if (op == 5) return "R7";
        if (op == 7) return "R10";
        if (lv == 8'hFF) return "R8";
        if (lv == 8'hFE) return "R4";
        return "R5";
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %02h expected %02h", req, what, act, exp);
        end
    endtask

    // Call just after a falling edge; returns just after the next one.
    task automatic run(input int op, input logic [7:0] nl);
        bit         e_allow;
        logic [7:0] e_code;
        bit         e_rst;
        logic [7:0] e_next;
        string      t;
        int         r0;
        e_allow = 1'b0; e_code = 8'h50; e_rst = 1'b0; e_next = m_lvl;
        r0 = rank(m_lvl);
        t  = tag(m_lvl, op);
        case (op)
            0: if (r0 == 2) e_code = 8'h4C; else e_allow = 1'b1;
            1, 2, 4: e_allow = (r0 == 0);
            3: begin e_allow = 1'b1; e_rst = 1'b1; e_next = 8'hFF; end
            5: e_allow = 1'b1;
            6: if (rank(nl) > r0) begin e_allow = 1'b1; e_next = nl; end
            default: e_allow = 1'b0;
        endcase
        if (e_allow) e_code = 8'h2E;
        req_valid = 1'b1; req_op = op[2:0]; req_level = nl;
        @(negedge clk);
        chk(rsp_valid == 1'b1, "R9", "rsp_valid", {7'd0, rsp_valid}, 8'h01);
        chk(rsp_allow == e_allow, t, "allow", {7'd0, rsp_allow}, {7'd0, e_allow});
        chk(rsp_code == e_code, t, "code", rsp_code, e_code);
        chk(rsp_restore == e_rst, "R6", "restore", {7'd0, rsp_restore}, {7'd0, e_rst});
        chk(level_code == e_next, t, "level", level_code, e_next);
        m_lvl = e_next;
        req_valid = 1'b0;
    endtask

    task automatic reach(input int lv);
        run(3, 8'h00);
        if (lv == 1) run(6, 8'hFE);
        if (lv == 2) run(6, 8'hFC);
    endtask

    initial begin
        logic [7:0] probes [6];
        probes = '{8'hFF, 8'hFE, 8'hFC, 8'h00, 8'h7F, 8'hFD};
        repeat (3) @(negedge clk);
        chk(level_code == 8'hFF, "R1", "reset level", level_code, 8'hFF);
        chk(rsp_valid == 1'b0, "R1", "reset rsp_valid", {7'd0, rsp_valid}, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);
        chk(rsp_valid == 1'b0, "R9", "idle rsp_valid", {7'd0, rsp_valid}, 8'h00);
        for (int lv = 0; lv < 3; lv++) begin
            for (int op = 0; op < 8; op++) begin
                if (op != 6) begin
                    reach(lv);
                    run(op, 8'h00);
                end
            end
            for (int p = 0; p < 6; p++) begin
                reach(lv);
                run(6, probes[p]);
            end
        end
        // Back-to-back: raise then read in the next cycle (R9 uses old level).
        reach(1);
        run(6, 8'hFC);
        run(0, 8'h00);
        @(negedge clk);
        chk(rsp_valid == 1'b0, "R9", "idle after burst", {7'd0, rsp_valid}, 8'h00);
        chk(level_code == 8'hFC, "R3", "level held", level_code, 8'hFC);
        if (!done) begin
            done = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            done = 1'b1;
            n_vec++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule